// File: doc/BRIEF.md
# Disk Tweak Multiply-by-Alpha Sequencer

This block produces the run of per-block tweak values that a narrow-block disk encryption mode needs inside one sector. A 128-bit starting tweak is loaded. This value is the sector number after it has already been encrypted, and it comes from outside the block. Each advance multiplies the current tweak by the field element x (alpha) in GF(2^128), reduced by x^128 + x^7 + x^2 + x + 1. After j advances the output therefore equals the starting tweak times alpha^j, and a block counter reports j next to the tweak.

Implementations disagree on where the polynomial terms sit inside the 128-bit block, so a two-bit mapping code is captured with every load. There are three mappings. In the first, the unity term is at the rightmost bit and the whole vector shifts. In the second, bytes are little-endian, so each byte shifts on its own and its carry passes into the next byte. In the third, the unity term is at the leftmost bit. Every load or advance completes in one clock cycle.

Top module: `tweak_alpha_seq`

## Requirements
- R1: During and right after reset, with no load since then, valid_o is 0, j_count_o is 0 and tweak_o is all zeros.
- R2: A load pulse makes tweak_o equal init_tweak_i, j_count_o equal 0 and valid_o equal 1 at the next clock edge, and it captures mode_i. When load and advance are high together, the load wins.
- R3: An advance while valid_o is 1 and load is low increments j_count_o by one and replaces tweak_o with tweak_o times x under the captured mapping, both at the next clock edge.
- R4: Mapping code 0: port bit tweak_o[k] holds the coefficient of x^k. Unity is at bit 0, which is the rightmost block bit (LSB of the last byte). When x^127 is set, a step shifts toward the top and XORs 8'h87 into tweak_o[7:0].
- R5: Mapping code 1: block byte b is tweak_o[127-8b -: 8], with byte 0 in tweak_o[127:120]. Bit i of byte b holds x^(8b+i). Carries run from byte 0 up to byte 15, and a carry out of byte 15 XORs 8'h87 into byte 0.
- R6: Mapping code 2: tweak_o[127-k] holds x^k, so unity is at the leftmost block bit, tweak_o[127].
- R7: Mapping code 3 behaves exactly like code 0.
- R8: A change of mode_i without a load has no effect on later steps. The mapping captured at the last load stays in use.
- R9: An advance before the first load after reset has no effect. valid_o, j_count_o and tweak_o stay 0.
- R10: An all-zero tweak stays all-zero under any number of advances in every mapping.
- R11: In a cycle with neither load nor advance, tweak_o, j_count_o and valid_o hold their values.
- R12: j_count_o counts modulo 2^JW, with JW=8 by default. After 256 advances it reads 0 again, and the tweak keeps stepping normally across that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Load pulse: take init_tweak_i and mode_i, clear the count |
| advance_i | input | 1 | Advance pulse: multiply the tweak by x |
| mode_i | input | 2 | Term mapping code, captured on load |
| init_tweak_i | input | 128 | Starting tweak (the encrypted sector number) |
| tweak_o | output | 128 | Current tweak, start times x^j |
| j_count_o | output | JW | Number of advances since the last load |
| valid_o | output | 1 | High once a tweak has been loaded |

## Verification
If the tweak register or the captured mapping goes wrong, tweak_o shows it on the first advance whose result depends on the damaged bits. A misrouted carry or feedback shows only in cycles where a byte top bit or x^127 is set, which is why the stimulus includes tweaks with the top term set and runs of more than 128 steps. A count fault appears on j_count_o at the very next edge. A mapping latched at the wrong time stays hidden until the step after mode_i changes.

// File: rtl/tas_pkg.sv
// Shared constants and mapping codes for the tweak sequencer.
// Assumes a 128-bit block made of 8-bit bytes.
package tas_pkg;
    localparam int BLK_W  = 128;
    localparam int BYTE_W = 8;
    localparam int NBYTES = BLK_W / BYTE_W;

    // Low-order feedback terms of x^128 + x^7 + x^2 + x + 1
    localparam logic [BYTE_W-1:0] FDBK = 8'h87;

    typedef enum logic [1:0] {
        MAP_RIGHT     = 2'd0,
        MAP_BYTE_LE   = 2'd1,
        MAP_LEFT      = 2'd2,
        MAP_RIGHT_ALT = 2'd3
    } map_mode_e;
endpackage

// File: rtl/tas_shift_step.sv
// One multiply-by-x step for a bit-contiguous mapping.
// REFLECT=0: port bit k is x^k, so the step shifts toward the top.
// REFLECT=1: port bit W-1-k is x^k, so the step shifts toward bit 0.
// Purely combinational. Assumes W > 8.
module tas_shift_step #(
    parameter int W       = 128,
    parameter bit REFLECT = 1'b0
) (
    input  logic [W-1:0] blk_i,
    output logic [W-1:0] blk_o
);
    import tas_pkg::*;

    // Bit-reversed copy of the feedback byte, used for the reflected layout
    function automatic logic [BYTE_W-1:0] rev8(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
        return r;
    endfunction

    generate
        if (REFLECT) begin : g_left
            // x^127 sits at bit 0; the feedback terms go to the top byte
            always_comb begin
                blk_o = {1'b0, blk_i[W-1:1]};
                if (blk_i[0]) blk_o[W-1 -: BYTE_W] = blk_o[W-1 -: BYTE_W] ^ rev8(FDBK);
            end
        end else begin : g_right
            // x^127 sits at bit W-1; the feedback terms go to the bottom byte
            always_comb begin
                blk_o = {blk_i[W-2:0], 1'b0};
                if (blk_i[W-1]) blk_o[BYTE_W-1:0] = blk_o[BYTE_W-1:0] ^ FDBK;
            end
        end
    endgenerate
endmodule

// File: rtl/tas_byte_step.sv
// One multiply-by-x step for the byte-wise little-endian mapping.
// Byte b occupies blk[W-1-8b -: 8]. Each byte shifts left, its top bit
// becomes the low bit of byte b+1, and the carry out of the last byte
// folds the feedback into byte 0. Purely combinational.
module tas_byte_step #(
    parameter int W = 128
) (
    input  logic [W-1:0] blk_i,
    output logic [W-1:0] blk_o
);
    import tas_pkg::*;
    localparam int NB = W / BYTE_W;

    logic [NB:0]  carry;
    logic [W-1:0] shifted;

    assign carry[0] = 1'b0;

    generate
        for (genvar b = 0; b < NB; b++) begin : g_byte
            localparam int HI = W - 1 - BYTE_W * b;
            // Per-byte shift with the carry taken from the lower-order byte
            assign shifted[HI -: BYTE_W] = {blk_i[HI-1 -: BYTE_W-1], carry[b]};
            assign carry[b+1]            = blk_i[HI];
        end
    endgenerate

    // Fold the carry out of the top-order byte into byte 0
    always_comb begin
        blk_o = shifted;
        if (carry[NB]) blk_o[W-1 -: BYTE_W] = shifted[W-1 -: BYTE_W] ^ FDBK;
    end
endmodule

// File: rtl/tas_jcount.sv
// Block counter: clears on load, increments on a step, wraps at 2^JW.
// Synchronous active-low reset.
module tas_jcount #(
    parameter int JW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [JW-1:0] cnt_o
);
    // Count register with clear taking priority over increment
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_o <= '0;
        else if (clr_i) cnt_o <= '0;
        else if (inc_i) cnt_o <= cnt_o + JW'(1);
    end
endmodule

// File: rtl/tweak_alpha_seq.sv
// Tweak sequencer top. Holds the current tweak, the mapping captured at
// load and the block counter, and picks the next-tweak value from three
// parallel step units. Assumes the starting tweak is already encrypted.
// Synchronous active-low reset; one operation per clock.
module tweak_alpha_seq #(
    parameter int JW = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic                     advance_i,
    input  logic [1:0]               mode_i,
    input  logic [tas_pkg::BLK_W-1:0] init_tweak_i,
    output logic [tas_pkg::BLK_W-1:0] tweak_o,
    output logic [JW-1:0]            j_count_o,
    output logic                     valid_o
);
    import tas_pkg::*;

    map_mode_e        mode_q;
    logic [BLK_W-1:0] nxt_right, nxt_left, nxt_byte, nxt_sel;
    logic             step_en;

    assign step_en = advance_i && !load_i && valid_o;

    tas_shift_step #(.W(BLK_W), .REFLECT(1'b0)) u_step_right (
        .blk_i(tweak_o), .blk_o(nxt_right)
    );
    tas_shift_step #(.W(BLK_W), .REFLECT(1'b1)) u_step_left (
        .blk_i(tweak_o), .blk_o(nxt_left)
    );
    tas_byte_step #(.W(BLK_W)) u_step_byte (
        .blk_i(tweak_o), .blk_o(nxt_byte)
    );

    tas_jcount #(.JW(JW)) u_jcount (
        .clk(clk), .rst_n(rst_n), .clr_i(load_i),
        .inc_i(step_en), .cnt_o(j_count_o)
    );

    // Select the step result for the mapping captured at load
    always_comb begin
        case (mode_q)
            MAP_BYTE_LE: nxt_sel = nxt_byte;
            MAP_LEFT:    nxt_sel = nxt_left;
            default:     nxt_sel = nxt_right;
        endcase
    end

    // Tweak, mapping and valid registers: load first, then step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tweak_o <= '0;
            mode_q  <= MAP_RIGHT;
            valid_o <= 1'b0;
        end else if (load_i) begin
            tweak_o <= init_tweak_i;
            mode_q  <= map_mode_e'(mode_i);
            valid_o <= 1'b1;
        end else if (step_en) begin
            tweak_o <= nxt_sel;
        end
    end
endmodule

// File: rtl/tas_checker.sv
// Property checker for tweak_alpha_seq, attached by bind below.
// Watches ports and the captured mapping register only.
module tas_checker #(
    parameter int JW = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load_i,
    input logic         advance_i,
    input logic [127:0] init_tweak_i,
    input logic [127:0] tweak_o,
    input logic [JW-1:0] j_count_o,
    input logic         valid_o,
    input logic [1:0]   mode_q
);
    a_r2_load_takes_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (tweak_o == $past(init_tweak_i)) && (j_count_o == '0) && valid_o);

    a_r3_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_i && !load_i && valid_o) |=> (j_count_o == $past(j_count_o) + JW'(1)));

    a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance_i && !load_i) |=> ($stable(tweak_o) && $stable(j_count_o) && $stable(valid_o)));

    a_r10_zero_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && tweak_o == '0) |=> (tweak_o == '0));

    a_r9_idle_before_load: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (j_count_o == '0 && tweak_o == '0));

    a_r8_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(mode_q));
endmodule

bind tweak_alpha_seq tas_checker #(.JW(JW)) u_chk (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .advance_i(advance_i),
    .init_tweak_i(init_tweak_i), .tweak_o(tweak_o), .j_count_o(j_count_o),
    .valid_o(valid_o), .mode_q(mode_q)
);

// File: tb/tweak_alpha_seq_tb.sv
// Self-checking bench: directed corners plus seeded random traffic,
// compared against a polynomial shift-and-reduce model.
module tweak_alpha_seq_tb;
    localparam int JW = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0, advance_i = 1'b0;
    logic [1:0]   mode_i = 2'd0;
    logic [127:0] init_tweak_i = '0;
    logic [127:0] tweak_o;
    logic [JW-1:0] j_count_o;
    logic         valid_o;

    int checks = 0, fails = 0;
    bit done = 0;

    // Reference state: polynomial value, mapping, count, valid
    logic [127:0] m_poly = '0;
    logic [1:0]   m_mode = 2'd0;
    int           m_j = 0;
    bit           m_valid = 0;

    always #2 clk = ~clk;

    tweak_alpha_seq #(.JW(JW)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .advance_i(advance_i),
        .mode_i(mode_i), .init_tweak_i(init_tweak_i), .tweak_o(tweak_o),
        .j_count_o(j_count_o), .valid_o(valid_o)
    );

    function automatic logic [127:0] mulx(input logic [127:0] p);
        logic [127:0] r = {p[126:0], 1'b0};
        if (p[127]) r ^= 128'h87;
        return r;
    endfunction

    // Polynomial (bit n = x^n) to port layout, per mapping code
    function automatic logic [127:0] to_port(input logic [127:0] p, input logic [1:0] md);
        logic [127:0] v = '0;
        case (md)
            2'd1: for (int b = 0; b < 16; b++) v[127-8*b -: 8] = p[8*b +: 8];
            2'd2: for (int k = 0; k < 128; k++) v[127-k] = p[k];
            default: v = p;
        endcase
        return v;
    endfunction

    function automatic logic [127:0] to_poly(input logic [127:0] v, input logic [1:0] md);
        logic [127:0] p = '0;
        case (md)
            2'd1: for (int b = 0; b < 16; b++) p[8*b +: 8] = v[127-8*b -: 8];
            2'd2: for (int k = 0; k < 128; k++) p[k] = v[127-k];
            default: p = v;
        endcase
        return p;
    endfunction

    task automatic check(input string tag);
        logic [127:0] exp_t = m_valid ? to_port(m_poly, m_mode) : '0;
        checks++;
        if (tweak_o !== exp_t || j_count_o !== JW'(m_j) || valid_o !== m_valid) begin
            fails++;
            $display("FAIL %s: got v=%0b j=%0d t=%h, expected v=%0b j=%0d t=%h",
                     tag, valid_o, j_count_o, tweak_o, m_valid, JW'(m_j), exp_t);
        end
    endtask

    // Drive one cycle at a falling edge, update the model, check at the next
    task automatic step(input bit ld, input bit adv, input logic [1:0] md,
                        input logic [127:0] tw, input string tag);
        load_i = ld; advance_i = adv; mode_i = md; init_tweak_i = tw;
        if (ld) begin
            m_poly = to_poly(tw, md); m_mode = md; m_j = 0; m_valid = 1;
        end else if (adv && m_valid) begin
            m_poly = mulx(m_poly); m_j = (m_j + 1) % (1 << JW);
        end
        @(negedge clk);
        load_i = 0; advance_i = 0;
        check(tag);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1619));
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset");

        // R9: advance before any load
        step(0, 1, 2'd1, rnd128(), "R9 advance before load");

        // R10: zero tweak in every mapping
        for (int md = 0; md < 4; md++) begin
            step(1, 0, md[1:0], '0, "R10 load zero");
            for (int i = 0; i < 40; i++) step(0, 1, md[1:0], '0, "R10 zero stays");
        end

        // R4/R5/R6/R7/R12: top term set, more than 256 steps per mapping
        for (int md = 0; md < 4; md++) begin
            logic [127:0] t0 = to_port(128'h1 << 127, md[1:0]) | to_port(128'h80, md[1:0]);
            step(1, 0, md[1:0], t0, "R2 load top term");
            for (int i = 0; i < 300; i++)
                step(0, 1, md[1:0], '0, md == 0 ? "R4 right map" : md == 1 ? "R5 byte map" :
                                     md == 2 ? "R6 left map" : "R7 alias map");
        end
        // R12: count wraps after 256 steps of a fresh sector
        step(1, 0, 2'd1, rnd128() | (128'h1 << 127), "R2 load");
        for (int i = 0; i < 256; i++) step(0, 1, 2'd1, '0, "R12 wrap");

        // R2: simultaneous load and advance, load wins
        step(0, 1, 2'd0, '0, "R3 step");
        step(1, 1, 2'd2, rnd128(), "R2 load beats advance");

        // R8: mode_i changes without load
        for (int i = 0; i < 10; i++) step(0, 1, i[1:0], '0, "R8 mode ignored");

        // R11: idle cycles
        for (int i = 0; i < 5; i++) step(0, 0, 2'd1, rnd128(), "R11 idle hold");

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            logic [127:0] tw = rnd128();
            if ($urandom_range(0, 3) == 0) tw[127] = 1'b1;
            if (r < 4)       step(1, 0, 2'($urandom), tw, "R2 random load");
            else if (r < 6)  step(1, 1, 2'($urandom), tw, "R2 random load+adv");
            else if (r < 85) step(0, 1, 2'($urandom), tw, "R3 random step");
            else             step(0, 0, 2'($urandom), tw, "R11 random idle");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule